// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It covers a small load/store instruction set: five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a word load, a word store and a branch taken when two registers are equal. Instruction and data storage are separate arrays inside the core. Because of this, a load reads data in the same cycle that it is fetched, and no instruction ever stalls.

Both arrays are filled from parameter images while reset is held. The instruction array is never written after reset. The data array is written on the clock edge and read combinationally. A debug port shows the address and the word of the instruction being executed, along with the register write that the instruction will commit on the next edge. A bench or a trace monitor can rebuild the full architectural history from these ports alone.

Top module: `sc_core`

## Requirements
- R1: While reset is low, the program counter reads 0. All 32 registers hold 0. Instruction word i is loaded from bits [32*i+31:32*i] of the instruction image, and data word i is loaded the same way from the data image.
- R2: The program counter is always word aligned. After any instruction other than a taken branch, it advances by exactly 4.
- R3: Opcode bits [31:26] = 0 selects a register operation on rs = bits [25:21] and rt = bits [20:16], with the result written to rd = bits [15:11]. Funct bits [5:0] select the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 and, 0x25 or, 0x2A signed less-than (result 1 or 0).
- R4: Register 0 always reads 0. When the destination is 0, the debug write strobe stays low and no register changes.
- R5: Opcode 0x23 loads into rt the data word addressed by rs plus the sign-extended bits [15:0]. The word index is the byte address divided by 4, taken modulo the data depth.
- R6: Opcode 0x2B stores rt to the data word addressed the same way as a load. No register write is reported.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the program counter becomes PC+4 plus the sign-extended bits [15:0] shifted left by 2. Otherwise it becomes PC+4. No register write is reported.
- R8: Any other opcode, and opcode 0 with any other funct value, changes no register and no data word, and only advances the program counter by 4.
- R9: Negative offsets are sign extended, both for backward branches and for load or store addresses below the base.
- R10: The debug instruction output equals the instruction word at index PC/4 modulo the instruction depth. The debug write outputs give the destination and the value the current instruction commits on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads both memory images |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_instr | output | 32 | Instruction word executing this cycle |
| dbg_we | output | 1 | A register write commits at the next edge |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Value of that write |

## Verification
The bench builds two copies of the core. The first has a 32-word instruction array and a 16-word data array, and runs a directed program. That program reaches every operation, signed compares, a write to register 0, a store followed by a load that reads it back, a negative load offset, taken and untaken branches, two undefined encodings, and a backward branch that loops over the whole program. The second copy has a 16-word instruction array and an 8-word data array, and runs a pseudo-random program generated from a fixed seed. Its small depths make address wrap-around, self-loops and random branch targets common. Each cycle, both copies are compared with an instruction-level model kept in the bench.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    opb_imm;
        logic    mem_read;
        logic    mem_write;
        logic    wb_from_mem;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                unique case (funct)
                    FN_ADD: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_SLT: begin ctrl.reg_write = 1'b1; ctrl.alu_op = ALU_SLT; end
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.opb_imm     = 1'b1;
                ctrl.mem_read    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.opb_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl.reg_write = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [XLEN-1:0]   rd_a,
    output logic [XLEN-1:0]   rd_b,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = opa & opb;
            ALU_OR:  y = opa | opb;
            ALU_ADD: y = opa + opb;
            ALU_SUB: y = opa - opb;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem
    import sc_core_pkg::*;
#(
    parameter int                      WORDS = 16,
    parameter logic [WORDS*XLEN-1:0]   IMAGE = '0,
    localparam int                     AW    = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   idx,
    input  logic            we,
    input  logic            re,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] mem_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= IMAGE[i*XLEN +: XLEN];
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = re ? mem_q[idx] : '0;

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int                         IMEM_WORDS = 16,
    parameter int                         DMEM_WORDS = 16,
    parameter logic [IMEM_WORDS*32-1:0]   IMEM_IMAGE = '0,
    parameter logic [DMEM_WORDS*32-1:0]   DMEM_IMAGE = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] dbg_pc,
    output logic [31:0] dbg_instr,
    output logic        dbg_we,
    output logic [4:0]  dbg_waddr,
    output logic [31:0] dbg_wdata
);

    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   br_target;
    logic [XLEN-1:0]   pc_next;
    logic [XLEN-1:0]   instr;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   opb;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   mem_rdata;
    logic [XLEN-1:0]   wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic              wb_en;
    ctrl_t             ctrl;

    // Instruction array: filled from the image under reset, read-only after.
    logic [XLEN-1:0] imem_q [IMEM_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] <= IMEM_IMAGE[i*XLEN +: XLEN];
        end
    end

    assign instr = imem_q[pc_q[IA_W+1:2]];

    // Program counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_plus4  = pc_q + 32'd4;
    assign imm_ext   = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_next   = (ctrl.is_branch && alu_zero) ? br_target : pc_plus4;

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wb_idx = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign wb_en  = ctrl.reg_write && (wb_idx != '0);

    sc_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (instr[25:21]),
        .ra_b  (instr[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (wb_en),
        .wa    (wb_idx),
        .wd    (wb_data)
    );

    assign opb = ctrl.opb_imm ? imm_ext : rt_val;

    sc_alu u_alu (
        .opa  (rs_val),
        .opb  (opb),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_dmem #(
        .WORDS (DMEM_WORDS),
        .IMAGE (DMEM_IMAGE)
    ) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (alu_y[DA_W+1:2]),
        .we    (ctrl.mem_write),
        .re    (ctrl.mem_read),
        .wdata (rt_val),
        .rdata (mem_rdata)
    );

    assign wb_data = ctrl.wb_from_mem ? mem_rdata : alu_y;

    assign dbg_pc    = pc_q;
    assign dbg_instr = instr;
    assign dbg_we    = wb_en;
    assign dbg_waddr = wb_idx;
    assign dbg_wdata = wb_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        we,
    input logic [4:0]  waddr
);

    logic [5:0]  opc;
    logic [31:0] sext;

    assign opc  = instr[31:26];
    assign sext = {{16{instr[15]}}, instr[15:0]};

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);                                                   // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_BEQ) |=> (pc == $past(pc) + 32'd4));                     // R2

    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr != 5'd0));                                             // R4

    AST_REG_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (we && opc == OPC_REG) |-> (waddr == instr[15:11]));                 // R3

    AST_LOAD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (we && opc == OPC_LOAD) |-> (waddr == instr[20:16]));                // R5

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_STORE) |-> !we);                                         // R6

    AST_BEQ_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BEQ) |-> !we);                                           // R7

    AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BEQ) |=> ((pc == $past(pc) + 32'd4) ||
                              (pc == $past(pc) + 32'd4 + ($past(sext) << 2)))); // R7

    AST_BEQ_SAME_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BEQ && instr[25:21] == instr[20:16])
        |=> (pc == $past(pc) + 32'd4 + ($past(sext) << 2)));                 // R9

    AST_OTHER_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_REG && opc != OPC_LOAD) |-> !we);                        // R8

endmodule

bind sc_core sc_core_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pc    (dbg_pc),
    .instr (dbg_instr),
    .we    (dbg_we),
    .waddr (dbg_waddr)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

    localparam int IW_A = 32, DW_A = 16;
    localparam int IW_B = 16, DW_B = 8;
    localparam int RUN_CYCLES = 400;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        logic [4:0] s = rs[4:0], t = rt[4:0], d = rd[4:0];
        return {6'h00, s, t, d, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        logic [4:0] s = rs[4:0], t = rt[4:0];
        logic [15:0] im = imm[15:0];
        return {op, s, t, im};
    endfunction

    function automatic logic [IW_A*32-1:0] build_prog_a();
        logic [IW_A*32-1:0] w = '0;
        w[ 0*32 +: 32] = enc_i(6'h23, 0, 1, 0);       // lw r1 = 5      R5
        w[ 1*32 +: 32] = enc_i(6'h23, 0, 2, 4);       // lw r2 = 7
        w[ 2*32 +: 32] = enc_i(6'h23, 0, 3, 8);       // lw r3 = -2
        w[ 3*32 +: 32] = enc_r(1, 2, 4, 6'h20);       // add r4 = 12    R3
        w[ 4*32 +: 32] = enc_r(1, 2, 5, 6'h22);       // sub r5 = -2
        w[ 5*32 +: 32] = enc_r(1, 2, 6, 6'h24);       // and r6 = 5
        w[ 6*32 +: 32] = enc_r(1, 2, 7, 6'h25);       // or  r7 = 7
        w[ 7*32 +: 32] = enc_r(3, 1, 8, 6'h2A);       // slt r8 = 1 (signed)
        w[ 8*32 +: 32] = enc_r(1, 3, 9, 6'h2A);       // slt r9 = 0
        w[ 9*32 +: 32] = enc_r(1, 2, 0, 6'h20);       // add r0: dropped R4
        w[10*32 +: 32] = enc_i(6'h2B, 0, 4, 12);      // sw r4 -> word 3 R6
        w[11*32 +: 32] = enc_i(6'h23, 4, 10, 0);      // lw r10 = 12
        w[12*32 +: 32] = enc_i(6'h23, 4, 11, -8);     // lw r11 = 7     R9
        w[13*32 +: 32] = enc_i(6'h04, 5, 3, 1);       // beq taken      R7
        w[14*32 +: 32] = enc_r(1, 1, 12, 6'h20);      // skipped
        w[15*32 +: 32] = enc_i(6'h04, 1, 2, 5);       // beq not taken
        w[16*32 +: 32] = 32'h0000_0000;               // undefined funct R8
        w[17*32 +: 32] = enc_i(6'h08, 1, 13, 3);      // undefined opcode R8
        w[18*32 +: 32] = enc_i(6'h04, 0, 0, -19);     // back to 0      R9
        return w;
    endfunction

    function automatic logic [DW_A*32-1:0] build_data_a();
        logic [DW_A*32-1:0] d = '0;
        d[0*32 +: 32] = 32'd5;
        d[1*32 +: 32] = 32'd7;
        d[2*32 +: 32] = 32'hFFFF_FFFE;
        d[3*32 +: 32] = 32'h8000_0000;
        return d;
    endfunction

    function automatic logic [IW_B*32-1:0] build_prog_b();
        logic [IW_B*32-1:0] w = '0;
        logic [31:0] s = 32'h1357_9BDF;
        logic [5:0]  fn;
        for (int i = 0; i < IW_B; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            case (s[30:28])
                3'd0: fn = 6'h20;
                3'd1: fn = 6'h22;
                3'd2: fn = 6'h24;
                3'd3: fn = 6'h25;
                default: fn = 6'h2A;
            endcase
            if (s[27:25] == 3'd0)
                w[i*32 +: 32] = enc_i(6'h3F, int'(s[10:8]), int'(s[13:11]), 0);
            else if (s[30:28] <= 3'd4)
                w[i*32 +: 32] = enc_r(int'(s[10:8]), int'(s[13:11]), int'(s[16:14]), fn);
            else if (s[30:28] == 3'd5)
                w[i*32 +: 32] = enc_i(6'h23, int'(s[10:8]), int'(s[13:11]), int'($signed(s[22:19])) * 4);
            else if (s[30:28] == 3'd6)
                w[i*32 +: 32] = enc_i(6'h2B, int'(s[10:8]), int'(s[13:11]), int'($signed(s[22:19])) * 4);
            else
                w[i*32 +: 32] = enc_i(6'h04, int'(s[10:8]), int'(s[13:11]), int'($signed(s[21:19])));
        end
        return w;
    endfunction

    function automatic logic [DW_B*32-1:0] build_data_b();
        logic [DW_B*32-1:0] d;
        logic [31:0] s = 32'h2468_ACE1;
        for (int i = 0; i < DW_B; i++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            d[i*32 +: 32] = (i % 2 == 0) ? {28'd0, s[31:28]} : s;
        end
        return d;
    endfunction

    localparam logic [IW_A*32-1:0] IMG_A = build_prog_a();
    localparam logic [DW_A*32-1:0] DAT_A = build_data_a();
    localparam logic [IW_B*32-1:0] IMG_B = build_prog_b();
    localparam logic [DW_B*32-1:0] DAT_B = build_data_b();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] pc_a, ins_a, wd_a, pc_b, ins_b, wd_b;
    logic        we_a, we_b;
    logic [4:0]  wa_a, wa_b;

    sc_core #(.IMEM_WORDS(IW_A), .DMEM_WORDS(DW_A), .IMEM_IMAGE(IMG_A), .DMEM_IMAGE(DAT_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_pc(pc_a), .dbg_instr(ins_a),
        .dbg_we(we_a), .dbg_waddr(wa_a), .dbg_wdata(wd_a));

    sc_core #(.IMEM_WORDS(IW_B), .DMEM_WORDS(DW_B), .IMEM_IMAGE(IMG_B), .DMEM_IMAGE(DAT_B)) u_dut_rnd (
        .clk(clk), .rst_n(rst_n), .dbg_pc(pc_b), .dbg_instr(ins_b),
        .dbg_we(we_b), .dbg_waddr(wa_b), .dbg_wdata(wd_b));

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] m_regs [2][32];
    logic [31:0] m_mem  [2][32];
    logic [31:0] m_pc   [2];

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] fetch(int k, logic [31:0] pc);
        int idx;
        if (k == 0) begin idx = int'(pc >> 2) % IW_A; return IMG_A[idx*32 +: 32]; end
        idx = int'(pc >> 2) % IW_B;
        return IMG_B[idx*32 +: 32];
    endfunction

    task automatic model_init();
        for (int k = 0; k < 2; k++) begin
            m_pc[k] = '0;
            for (int r = 0; r < 32; r++) m_regs[k][r] = '0;
            for (int j = 0; j < 32; j++) m_mem[k][j] = '0;
        end
        for (int j = 0; j < DW_A; j++) m_mem[0][j] = DAT_A[j*32 +: 32];
        for (int j = 0; j < DW_B; j++) m_mem[1][j] = DAT_B[j*32 +: 32];
    endtask

    // Compare one instance against the instruction-level model, then retire.
    task automatic step(int k, logic [31:0] pc, logic [31:0] ins, logic we, logic [4:0] wa, logic [31:0] wd);
        logic [31:0] i_exp, a, b, imm, res, addr, npc;
        logic [5:0]  op, fn;
        int rs, rt, rd, dw, midx;
        logic        ewe;
        logic [4:0]  ewa;
        string       tag;
        dw    = (k == 0) ? DW_A : DW_B;
        i_exp = fetch(k, m_pc[k]);
        chk("R2", "pc", pc, m_pc[k]);
        chk("R10", "instr", ins, i_exp);
        op = i_exp[31:26]; fn = i_exp[5:0];
        rs = int'(i_exp[25:21]); rt = int'(i_exp[20:16]); rd = int'(i_exp[15:11]);
        a = m_regs[k][rs]; b = m_regs[k][rt];
        imm = {{16{i_exp[15]}}, i_exp[15:0]};
        npc = m_pc[k] + 32'd4;
        ewe = 1'b0; ewa = 5'd0; res = '0; tag = "R8";
        addr = a + imm;
        midx = int'(addr >> 2) % dw;
        if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
            case (fn)
                6'h20: res = a + b;
                6'h22: res = a - b;
                6'h24: res = a & b;
                6'h25: res = a | b;
                default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            endcase
            ewa = rd[4:0]; ewe = (rd != 0); tag = (rd == 0) ? "R4" : "R3";
        end else if (op == 6'h23) begin
            res = m_mem[k][midx]; ewa = rt[4:0]; ewe = (rt != 0);
            tag = (rt == 0) ? "R4" : (imm[31] ? "R9" : "R5");
        end else if (op == 6'h2B) begin
            m_mem[k][midx] = b; tag = "R6";
        end else if (op == 6'h04) begin
            tag = imm[31] ? "R9" : "R7";
            if (a == b) npc = m_pc[k] + 32'd4 + (imm << 2);
        end
        chk(tag, "write strobe", {31'd0, we}, {31'd0, ewe});
        if (ewe) begin
            chk(tag, "write addr", {27'd0, wa}, {27'd0, ewa});
            chk(tag, "write data", wd, res);
            m_regs[k][rd == 0 && op == 6'h00 ? 0 : int'(ewa)] = res;
        end
        m_regs[k][0] = '0;
        m_pc[k] = npc;
    endtask

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset pc A", pc_a, 32'd0);
        chk("R1", "reset instr A", ins_a, IMG_A[31:0]);
        chk("R1", "reset pc B", pc_b, 32'd0);
        chk("R1", "reset instr B", ins_b, IMG_B[31:0]);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        step(0, pc_a, ins_a, we_a, wa_a, wd_a);
        step(1, pc_b, ins_b, we_b, wa_b, wd_b);
        for (int c = 1; c < RUN_CYCLES; c++) begin
            @(negedge clk);
            #1;
            step(0, pc_a, ins_a, we_a, wa_a, wd_a);
            step(1, pc_b, ins_b, we_b, wa_b, wd_b);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not complete got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule